// File: doc/BRIEF.md
# Packed Q15 Multiply-Subtract with Rounding

This block is a two-lane signed fractional datapath. Each 16-bit lane takes one halfword from operand A and one from operand B and forms their signed product. It scales the product by a left shift of 0 to 3 places and subtracts it from that lane's accumulator. It then adds half of a result LSB for round-to-nearest and clamps the sum to the signed 32-bit range. The upper 16 bits of the clamped value are the lane's result. The two lane results are packed into one 32-bit output word.

A pairing select chooses which halfwords of A and B are multiplied in each lane. The accumulator comes in one of two forms. In packed form, one 32-bit word holds a 16-bit accumulator per lane, and each lane's value is used as the top half of a 32-bit number. In wide form, each lane receives a full 32-bit accumulator word. The shift-by-one case where both factors are minus one has its product pinned to the largest positive 32-bit value. There is a single register stage. A valid strobe goes with the inputs, and the registered result comes out one clock later with its own valid and a per-lane clamp flag.

Top module: `frac_msub_rnd`

## Requirements
- R1: `pair_sel` picks the factors. Upper lane = A[31:16] times (B[15:0] for codes 0 and 2, B[31:16] for codes 1 and 3). Lower lane = A[15:0] times (B[31:16] for code 0, B[15:0] for codes 1, 2 and 3).
- R2: Each lane product is the exact signed 16x16 product multiplied by 2^`shift`, for `shift` from 0 to 3, with no truncation.
- R3: When both factors of a lane are 0x8000 and `shift` is 1, that lane's product is 0x7FFFFFFF in place of +2^31. The factors 0x8000 and 0x8000 at any other shift are not pinned.
- R4: With `acc_wide`=0, the upper lane's accumulator is {acc_lower[31:16], 16'h0000} and the lower lane's is {acc_lower[15:0], 16'h0000}, both read as signed 32-bit values. `acc_upper` has no effect.
- R5: With `acc_wide`=1, the upper lane's accumulator is `acc_upper` and the lower lane's is `acc_lower`, both full signed 32-bit values.
- R6: Each lane computes accumulator - product + 0x8000 exactly and clamps it to [-2^31, 2^31-1]. Bits 31:16 of the clamped value are the lane result. The upper lane drives `result[31:16]` and the lower lane drives `result[15:0]`.
- R7: `sat_flag[1]` (upper lane) and `sat_flag[0]` (lower lane) are 1 exactly when that lane's clamp changed the value. The pinned product of R3 does not set a flag by itself.
- R8: `out_valid` equals `in_valid` from the previous clock. The result and flags for an accepted input appear in that same cycle.
- R9: While `in_valid` is 0, `result` and `sat_flag` keep their values, whatever the other inputs do.
- R10: A synchronous active-high `rst` clears `out_valid`, `result` and `sat_flag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operands are valid this cycle |
| op_a | input | 32 | Packed signed halfwords, factor source A |
| op_b | input | 32 | Packed signed halfwords, factor source B |
| acc_upper | input | 32 | Upper-lane accumulator in wide form |
| acc_lower | input | 32 | Lower-lane accumulator in wide form; both packed halfwords in packed form |
| acc_wide | input | 1 | 1 selects wide accumulators, 0 selects packed |
| shift | input | 2 | Product left shift, 0 to 3 |
| pair_sel | input | 2 | Halfword pairing code |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Packed rounded lane results |
| sat_flag | output | 2 | Per-lane clamp indicator |

## Verification
The bench drives minus-one times minus-one at shift 1 with a wide accumulator of 0x00007FFF. Here the pinned product and the true product +2^31 round to different upper halves (0x8001 against 0x8000), so a design that skips the pin, or applies it at every shift, gives the wrong result. It also drives shift 2 with the same factors and a zero accumulator. This drives the exact difference past -2^31, so a design that computes in only 32 bits would wrap to a positive value and miss the clamp. Every pairing code is run with distinct halfwords, which exposes a swapped half or a wrong lane order. Packed vectors carry junk on `acc_upper`, and idle cycles change every other input, so a design that leaks these into the result or updates while idle is caught.

// File: rtl/frac_msub_pkg.sv
package frac_msub_pkg;

  // Halfword pairing codes; code 3 aliases the same-half pairing.
  typedef enum logic [1:0] {
    PAIR_CROSS    = 2'd0,
    PAIR_SAME     = 2'd1,
    PAIR_MIX      = 2'd2,
    PAIR_SAME_ALT = 2'd3
  } pair_e;

  localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/frac_msub_pair.sv
module frac_msub_pair
  import frac_msub_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0] a_word,
  input  logic [2*HW-1:0] b_word,
  input  pair_e           sel,
  output logic [HW-1:0]   up_x,
  output logic [HW-1:0]   up_y,
  output logic [HW-1:0]   dn_x,
  output logic [HW-1:0]   dn_y
);
  localparam int W = 2 * HW;

  always_comb begin
    up_x = a_word[W-1:HW];
    dn_x = a_word[HW-1:0];
    unique case (sel)
      PAIR_CROSS: begin
        up_y = b_word[HW-1:0];
        dn_y = b_word[W-1:HW];
      end
      PAIR_MIX: begin
        up_y = b_word[HW-1:0];
        dn_y = b_word[HW-1:0];
      end
      default: begin
        up_y = b_word[W-1:HW];
        dn_y = b_word[HW-1:0];
      end
    endcase
  end

endmodule

// File: rtl/frac_msub_acc.sv
module frac_msub_acc #(
  parameter int HW = 16
) (
  input  logic                wide,
  input  logic [2*HW-1:0]     src_up,
  input  logic [2*HW-1:0]     src_dn,
  output logic signed [2*HW-1:0] acc_up,
  output logic signed [2*HW-1:0] acc_dn
);
  localparam int W = 2 * HW;

  always_comb begin
    if (wide) begin
      acc_up = src_up;
      acc_dn = src_dn;
    end else begin
      acc_up = {src_dn[W-1:HW], {HW{1'b0}}};
      acc_dn = {src_dn[HW-1:0], {HW{1'b0}}};
    end
  end

endmodule

// File: rtl/frac_msub_lane.sv
module frac_msub_lane #(
  parameter int HW  = 16,
  parameter int SHW = 2
) (
  input  logic [HW-1:0]          fx,
  input  logic [HW-1:0]          fy,
  input  logic [SHW-1:0]         n,
  input  logic signed [2*HW-1:0] acc,
  output logic [HW-1:0]          q,
  output logic                   clamped
);
  localparam int W  = 2 * HW;
  localparam int PW = W + (1 << SHW);
  localparam int EW = PW + 2;
  localparam logic [HW-1:0]          MINV   = {1'b1, {(HW-1){1'b0}}};
  localparam logic signed [PW-1:0]   P_PIN  = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0]   RND    = {{(EW-HW){1'b0}}, 1'b1, {(HW-1){1'b0}}};
  localparam logic signed [EW-1:0]   LIM_HI = {{(EW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0]   LIM_LO = {{(EW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [W-1:0]  raw;
  logic signed [PW-1:0] raw_ext;
  logic signed [PW-1:0] prod;
  logic                 pin;
  logic signed [EW-1:0] diff;
  logic [W-1:0]         sat_val;

  always_comb begin
    raw     = $signed(fx) * $signed(fy);
    raw_ext = {{(PW-W){raw[W-1]}}, raw};
    pin     = (fx == MINV) && (fy == MINV) && (n == SHW'(1));
    prod    = pin ? P_PIN : (raw_ext <<< n);
    diff    = {{(EW-W){acc[W-1]}}, acc} - {{(EW-PW){prod[PW-1]}}, prod} + RND;
    if (diff > LIM_HI) begin
      sat_val = LIM_HI[W-1:0];
      clamped = 1'b1;
    end else if (diff < LIM_LO) begin
      sat_val = LIM_LO[W-1:0];
      clamped = 1'b1;
    end else begin
      sat_val = diff[W-1:0];
      clamped = 1'b0;
    end
    q = sat_val[W-1:HW];
  end

endmodule

// File: rtl/frac_msub_rnd.sv
module frac_msub_rnd
  import frac_msub_pkg::*;
#(
  parameter int HW  = 16,
  parameter int SHW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2*HW-1:0]   op_a,
  input  logic [2*HW-1:0]   op_b,
  input  logic [2*HW-1:0]   acc_upper,
  input  logic [2*HW-1:0]   acc_lower,
  input  logic              acc_wide,
  input  logic [SHW-1:0]    shift,
  input  logic [1:0]        pair_sel,
  output logic              out_valid,
  output logic [2*HW-1:0]   result,
  output logic [NUM_LANES-1:0] sat_flag
);
  localparam int W = 2 * HW;

  logic [HW-1:0]        fx [NUM_LANES];
  logic [HW-1:0]        fy [NUM_LANES];
  logic signed [W-1:0]  acc_v [NUM_LANES];
  logic [HW-1:0]        lane_q [NUM_LANES];
  logic [NUM_LANES-1:0] lane_sat;
  logic [W-1:0]         packed_q;

  frac_msub_pair #(.HW(HW)) u_pair (
    .a_word (op_a),
    .b_word (op_b),
    .sel    (pair_e'(pair_sel)),
    .up_x   (fx[1]),
    .up_y   (fy[1]),
    .dn_x   (fx[0]),
    .dn_y   (fy[0])
  );

  frac_msub_acc #(.HW(HW)) u_acc (
    .wide   (acc_wide),
    .src_up (acc_upper),
    .src_dn (acc_lower),
    .acc_up (acc_v[1]),
    .acc_dn (acc_v[0])
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    frac_msub_lane #(.HW(HW), .SHW(SHW)) u_lane (
      .fx      (fx[g]),
      .fy      (fy[g]),
      .n       (shift),
      .acc     (acc_v[g]),
      .q       (lane_q[g]),
      .clamped (lane_sat[g])
    );
    assign packed_q[g*HW +: HW] = lane_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= packed_q;
        sat_flag <= lane_sat;
      end
    end
  end

  // R8: valid is a one-cycle delayed copy of the input strobe
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9: idle cycles leave the output word and flags untouched
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(sat_flag)));
  // R7: a raised clamp flag means the lane holds a range limit
  a_r7_clamp_up: assert property (@(posedge clk) disable iff (rst)
    sat_flag[1] |-> (result[W-1:HW] == {1'b0, {(HW-1){1'b1}}} ||
                     result[W-1:HW] == {1'b1, {(HW-1){1'b0}}}));
  a_r7_clamp_dn: assert property (@(posedge clk) disable iff (rst)
    sat_flag[0] |-> (result[HW-1:0] == {1'b0, {(HW-1){1'b1}}} ||
                     result[HW-1:0] == {1'b1, {(HW-1){1'b0}}}));
  // R10: the cycle after reset the outputs are cleared
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && sat_flag == '0));

endmodule

// File: tb/frac_msub_rnd_test.sv
`timescale 1ns/1ps
module frac_msub_rnd_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] op_a, op_b, acc_upper, acc_lower;
  logic        acc_wide;
  logic [1:0]  shift;
  logic [1:0]  pair_sel;
  logic        out_valid;
  logic [31:0] result;
  logic [1:0]  sat_flag;

  int checks = 0;
  int fails  = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;
  string cur_tag = "R10";

  // reference state
  logic        m_valid;
  logic [31:0] m_result;
  logic [1:0]  m_sat;
  string       m_tag;

  always #2 clk = ~clk;

  frac_msub_rnd uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_upper(acc_upper), .acc_lower(acc_lower), .acc_wide(acc_wide),
    .shift(shift), .pair_sel(pair_sel), .out_valid(out_valid),
    .result(result), .sat_flag(sat_flag)
  );

  function automatic void ref_lane(input logic [15:0] x, input logic [15:0] y,
                                   input longint acc, input int n,
                                   output logic [15:0] r, output logic s);
    longint p, d;
    if (x == 16'h8000 && y == 16'h8000 && n == 1) p = 64'sh7FFF_FFFF;
    else p = longint'($signed(x)) * longint'($signed(y)) * (longint'(1) << n);
    d = acc - p + 32768;
    s = 1'b0;
    if (d > 64'sh7FFF_FFFF) begin d = 64'sh7FFF_FFFF; s = 1'b1; end
    else if (d < -64'sh8000_0000) begin d = -64'sh8000_0000; s = 1'b1; end
    r = d[31:16];
  endfunction

  always @(posedge clk) begin
    logic [15:0] ux, uy, lx, ly, ru, rl;
    logic su, sl;
    longint au, al;
    if (rst) begin
      m_valid  <= 1'b0;
      m_result <= '0;
      m_sat    <= '0;
      m_tag    <= "R10";
    end else begin
      m_valid <= in_valid;
      m_tag   <= in_valid ? cur_tag : "R9";
      if (in_valid) begin
        ux = op_a[31:16];
        lx = op_a[15:0];
        case (pair_sel)
          2'd0: begin uy = op_b[15:0];  ly = op_b[31:16]; end
          2'd2: begin uy = op_b[15:0];  ly = op_b[15:0];  end
          default: begin uy = op_b[31:16]; ly = op_b[15:0]; end
        endcase
        if (acc_wide) begin
          au = longint'($signed(acc_upper));
          al = longint'($signed(acc_lower));
        end else begin
          au = longint'($signed({acc_lower[31:16], 16'h0000}));
          al = longint'($signed({acc_lower[15:0], 16'h0000}));
        end
        ref_lane(ux, uy, au, int'(shift), ru, su);
        ref_lane(lx, ly, al, int'(shift), rl, sl);
        m_result <= {ru, rl};
        m_sat    <= {su, sl};
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      checks++;
      if (out_valid !== m_valid) begin
        fails++;
        $display("FAIL R8 out_valid got %b exp %b", out_valid, m_valid);
      end
      checks++;
      if (result !== m_result) begin
        fails++;
        $display("FAIL %s R6 result got %h exp %h", m_tag, result, m_result);
      end
      checks++;
      if (sat_flag !== m_sat) begin
        fails++;
        $display("FAIL %s R7 sat_flag got %b exp %b", m_tag, sat_flag, m_sat);
      end
    end
  end

  task automatic drive(input string tag, input logic v, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] au,
                       input logic [31:0] al, input logic w,
                       input logic [1:0] n, input logic [1:0] ps);
    cur_tag   = tag;
    in_valid  = v;
    op_a      = a;
    op_b      = b;
    acc_upper = au;
    acc_lower = al;
    acc_wide  = w;
    shift     = n;
    pair_sel  = ps;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0; op_a = '0; op_b = '0; acc_upper = '0; acc_lower = '0;
    acc_wide = 1'b0; shift = '0; pair_sel = '0;
    @(negedge clk);
    chk_en = 1'b1;                       // R10 reset state checked here
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 pairing codes with distinct halfwords
    drive("R1", 1, 32'h1234_0567, 32'h0321_7654, 0, 0, 1, 0, 2'd0);
    drive("R1", 1, 32'h1234_0567, 32'h0321_7654, 0, 0, 1, 0, 2'd1);
    drive("R1", 1, 32'h1234_0567, 32'h0321_7654, 0, 0, 1, 0, 2'd2);
    drive("R1", 1, 32'hF234_0567, 32'h0321_8654, 0, 0, 1, 1, 2'd3);
    // R2 shifts
    drive("R2", 1, 32'h0123_FEDC, 32'h0456_0789, 0, 0, 1, 2, 2'd1);
    drive("R2", 1, 32'h0123_FEDC, 32'h0456_0789, 0, 0, 1, 3, 2'd1);
    // R3 pinned product: wide acc 0x7FFF separates pin from exact
    drive("R3", 1, 32'h8000_8000, 32'h8000_8000, 32'h0000_7FFF, 32'h0000_7FFF, 1, 1, 2'd1);
    drive("R3", 1, 32'h8000_8000, 32'h8000_8000, 32'h0000_7FFF, 32'h0000_7FFF, 1, 0, 2'd1);
    drive("R3", 1, 32'h8000_8000, 32'h8000_8000, 0, 0, 1, 2, 2'd0);
    // R4 packed accumulator with junk on acc_upper
    drive("R4", 1, 32'h1000_E000, 32'h2000_3000, 32'hDEAD_BEEF, 32'h4000_C000, 0, 1, 2'd1);
    drive("R4", 1, 32'h8000_8000, 32'h8000_8000, 32'h1357_9BDF, 32'h8000_7FFF, 0, 1, 2'd1);
    // R5 wide accumulators
    drive("R5", 1, 32'h0101_0202, 32'h0303_0404, 32'h7000_1234, 32'h8FFF_4321, 1, 1, 2'd0);
    // R7 positive and negative clamps
    drive("R7", 1, 32'h7FFF_7FFF, 32'h8000_7FFF, 32'h7FFF_0000, 32'h8000_0000, 1, 3, 2'd1);
    // R9 idle with changed inputs
    drive("R9", 0, 32'hAAAA_5555, 32'h5555_AAAA, 32'h1111_1111, 32'h2222_2222, 1, 3, 2'd2);
    drive("R9", 0, 32'h0F0F_F0F0, 32'h7777_8888, 32'h3333_3333, 32'h4444_4444, 0, 2, 2'd0);
    // R6 random sweep
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if ($urandom % 8 == 0) a = 32'h8000_8000;
      if ($urandom % 8 == 0) b = 32'h8000_8000;
      drive("R6", ($urandom % 4) != 0, a, b, $urandom, $urandom,
            1'($urandom), 2'($urandom), 2'($urandom));
    end
    // R10 reset mid-stream
    drive("R10", 1, 32'h1234_5678, 32'h7654_3210, 0, 32'h1111_2222, 0, 1, 2'd1);
    rst = 1'b1;
    drive("R10", 1, 32'h1234_5678, 32'h7654_3210, 0, 32'h1111_2222, 0, 1, 2'd1);
    drive("R10", 0, 0, 0, 0, 0, 0, 0, 2'd0);
    rst = 1'b0;
    drive("R8", 1, 32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 2'd1);
    drive("R8", 0, 0, 0, 0, 0, 0, 0, 2'd1);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule